// File: doc/BRIEF.md
# Autoreload Timer with Status Register

A 12-bit up-counter with a byte-wide register interface. Its counter clock is chosen by a two-bit field in the control/status register. The counter can be stopped, advanced on each cycle in which a 1 ms tick input is high, or advanced on every system clock cycle. When the counter is at its maximum value (FFFh) and advances, it does not wrap to zero. It loads a programmable 12-bit start value instead and raises an overflow flag.

A second programmable 12-bit value sets a compare flag whenever the counter advances onto it. Both flags are cleared as a side effect of reading the control/status register. Each flag drives an interrupt output that is gated by its own enable bit. The counter is read through two byte addresses. Reading the low byte captures the top nibble, so that a later high-byte read matches the low byte read before it.

Software selects a clock source, programs the start and compare values, and services the interrupts. To service them it reads the status register, which both reports the flags and acknowledges them.

Top module: `autoreload_timer`

## Requirements
- R1: After reset every readable register returns 00h, and ovf_irq, cmp_irq and cmp_flag_o are low.
- R2: The clock-select field picks how the counter advances. 2'b00 and 2'b11 hold the counter. 2'b01 advances it once in each cycle in which tick_ms is high. 2'b10 advances it in every cycle.
- R3: On each advance the counter goes up by one. From FFFh it goes to the start value. The start value is written at address 3 (bits 7:0) and address 4 (bits 11:8, taken from the data's low nibble), and address 4 reads back with its upper nibble zero.
- R4: An advance from FFFh to the start value sets the overflow flag, which is bit 2 of the status register at address 0.
- R5: A read of address 0 returns the flags as they were before the read and clears the overflow and compare flags. A flag that is set in the same cycle as that read stays set. A write to address 0 leaves both flags unchanged.
- R6: Status register layout: bits 7:5 read 0, bits 4:3 are the clock select, bit 1 is the overflow interrupt enable and bit 0 is the compare interrupt enable. All of these are writable except bits 7:5 and bit 2.
- R7: ovf_irq is high exactly when the overflow flag and the overflow enable are both set. cmp_irq is high exactly when the compare flag and the compare enable are both set.
- R8: The compare flag is set when the counter advances onto the compare value. The compare value is written at address 5 (bits 7:0) and address 6 (low nibble, bits 11:8). The flag's state is shown on cmp_flag_o.
- R9: A read of address 1 returns counter bits 7:0 and captures bits 11:8. A read of address 2 returns the captured nibble in its low four bits and zero in its upper four bits.
- R10: Read data appears on bus_rdata in the cycle after bus_rd is sampled high. Address 7 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | 1 ms timebase tick, one cycle wide |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovf_irq | output | 1 | Masked overflow interrupt |
| cmp_irq | output | 1 | Masked compare interrupt |
| cmp_flag_o | output | 1 | Raw compare flag |

## Verification
The counter first runs from zero on the system clock through a full pass. This shows the difference between reloading from the start value and wrapping to zero, and it also hits the compare value early in the pass. The start value is then set to FFEh, so an overflow happens every second cycle. Back-to-back status reads then fall both on cycles that set the flag and on cycles that do not, which tests that a flag set during a clearing read is kept. The tick source is driven with an irregular tick pattern, and the stopped and reserved selects are run idle, so each clock source is told apart by the count it leaves. A high-byte read taken long after the low-byte read shows whether the captured nibble or the live count is returned.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_REL_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_REL_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd6;

  typedef enum logic [1:0] {
    CK_OFF  = 2'b00,
    CK_TICK = 2'b01,
    CK_SYS  = 2'b10,
    CK_RSV  = 2'b11
  } ck_sel_e;
endpackage

// File: rtl/atr_clksel.sv
module atr_clksel
  import atr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       tick_ms,
  output logic       adv
);
  always_comb begin
    case (ck_sel_e'(sel))
      CK_TICK: adv = tick_ms;
      CK_SYS:  adv = 1'b1;
      default: adv = 1'b0;
    endcase
  end
endmodule

// File: rtl/atr_split_reg.sv
module atr_split_reg #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  val
);
  localparam int HI_W = CNT_W - DATA_W;

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else begin
      if (wr_lo) val[DATA_W-1:0]     <= wdata;
      if (wr_hi) val[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
    end
  end
endmodule

// File: rtl/atr_counter.sv
module atr_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             cmp_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             at_max;
  logic [CNT_W-1:0] cnt_nxt;

  assign at_max  = (cnt == CNT_MAX);
  assign cnt_nxt = at_max ? reload : cnt + 1'b1;
  assign ovf_evt = adv && at_max;
  assign cmp_evt = adv && (cnt_nxt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/atr_regs.sv
module atr_regs
  import atr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf_evt,
  input  logic              cmp_evt,
  output logic [1:0]        sel,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              ovf_irq,
  output logic              cmp_irq
);
  localparam int HI_W = CNT_W - DATA_W;

  logic            ovfie_q, cmpie_q;
  logic [HI_W-1:0] shadow_q;
  logic            stat_rd, stat_wr;
  logic            ovf_d, cmp_d, ovfie_d, cmpie_d;
  logic [1:0]      sel_d;
  logic [DATA_W-1:0] rd_mux;
  logic            unused_wd;

  assign unused_wd = ^{bus_wdata[DATA_W-1:5], bus_wdata[2]};
  assign stat_rd   = bus_rd && (bus_addr == A_STAT);
  assign stat_wr   = bus_wr && (bus_addr == A_STAT);

  assign ovf_d   = ovf_evt | (ovf_flag & ~stat_rd);
  assign cmp_d   = cmp_evt | (cmp_flag & ~stat_rd);
  assign sel_d   = stat_wr ? bus_wdata[4:3] : sel;
  assign ovfie_d = stat_wr ? bus_wdata[1]   : ovfie_q;
  assign cmpie_d = stat_wr ? bus_wdata[0]   : cmpie_q;

  atr_split_reg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rel (
    .clk(clk), .rst(rst),
    .wr_lo(bus_wr && bus_addr == A_REL_LO),
    .wr_hi(bus_wr && bus_addr == A_REL_HI),
    .wdata(bus_wdata), .val(reload)
  );

  atr_split_reg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst),
    .wr_lo(bus_wr && bus_addr == A_CMP_LO),
    .wr_hi(bus_wr && bus_addr == A_CMP_HI),
    .wdata(bus_wdata), .val(cmp_val)
  );

  always_comb begin
    case (bus_addr)
      A_STAT:   rd_mux = DATA_W'({sel, ovf_flag, ovfie_q, cmpie_q});
      A_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      A_CNT_HI: rd_mux = DATA_W'(shadow_q);
      A_REL_LO: rd_mux = reload[DATA_W-1:0];
      A_REL_HI: rd_mux = DATA_W'(reload[CNT_W-1:DATA_W]);
      A_CMP_LO: rd_mux = cmp_val[DATA_W-1:0];
      A_CMP_HI: rd_mux = DATA_W'(cmp_val[CNT_W-1:DATA_W]);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= '0;
      ovfie_q   <= 1'b0;
      cmpie_q   <= 1'b0;
      ovf_flag  <= 1'b0;
      cmp_flag  <= 1'b0;
      ovf_irq   <= 1'b0;
      cmp_irq   <= 1'b0;
      shadow_q  <= '0;
      bus_rdata <= '0;
    end else begin
      sel       <= sel_d;
      ovfie_q   <= ovfie_d;
      cmpie_q   <= cmpie_d;
      ovf_flag  <= ovf_d;
      cmp_flag  <= cmp_d;
      ovf_irq   <= ovf_d & ovfie_d;
      cmp_irq   <= cmp_d & cmpie_d;
      if (bus_rd && bus_addr == A_CNT_LO) shadow_q <= cnt[CNT_W-1:DATA_W];
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/autoreload_timer.sv
module autoreload_timer
  import atr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ovf_irq,
  output logic              cmp_irq,
  output logic              cmp_flag_o
);
  logic [1:0]       sel_w;
  logic             adv_w;
  logic [CNT_W-1:0] cnt_w, reload_w, cmp_val_w;
  logic             ovf_evt_w, cmp_evt_w, ovf_flag_w, cmp_flag_w;

  atr_clksel u_clksel (.sel(sel_w), .tick_ms(tick_ms), .adv(adv_w));

  atr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv_w), .reload(reload_w), .cmp_val(cmp_val_w),
    .cnt(cnt_w), .ovf_evt(ovf_evt_w), .cmp_evt(cmp_evt_w)
  );

  atr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt_w),
    .ovf_evt(ovf_evt_w), .cmp_evt(cmp_evt_w), .sel(sel_w), .reload(reload_w),
    .cmp_val(cmp_val_w), .ovf_flag(ovf_flag_w), .cmp_flag(cmp_flag_w),
    .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  assign cmp_flag_o = cmp_flag_w;
endmodule

// File: rtl/atr_checker.sv
module atr_checker
  import atr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cmp_flag_o,
  input logic              cmp_irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              adv,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  reload,
  input logic [1:0]        sel
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_sys_moves: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b10) |=> (cnt != $past(cnt)));

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00 || sel == 2'b11) |=> $stable(cnt));

  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == CMAX) |=> (cnt == $past(reload)));

  a_r4_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == CMAX) |=> ovf_flag);

  a_r5_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT && !(adv && cnt == CMAX)) |=> !ovf_flag);

  a_r7_cmp_irq_gated: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |-> cmp_flag_o);

  a_r8_cmp_fall_on_read: assert property (@(posedge clk) disable iff (rst)
    $fell(cmp_flag_o) |-> $past(bus_rd && bus_addr == A_STAT));
endmodule

bind autoreload_timer atr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .cmp_flag_o(cmp_flag_o), .cmp_irq(cmp_irq), .cnt(cnt_w), .adv(adv_w),
  .ovf_flag(ovf_flag_w), .reload(reload_w), .sel(sel_w)
);

// File: tb/autoreload_timer_tb.sv
`timescale 1ns/1ps
module autoreload_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ovf_irq, cmp_irq, cmp_flag_o;

  always #2 clk = ~clk;

  autoreload_timer u_dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq),
    .cmp_flag_o(cmp_flag_o)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;

  // model state
  logic [11:0] m_cnt = '0, m_rel = '0, m_cmp = '0;
  logic [1:0]  m_sel = '0;
  logic        m_ovf = 0, m_cmp_f = 0, m_ovfie = 0, m_cmpie = 0;
  logic [3:0]  m_sh = '0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data the cycle after the read
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (!rst && rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  // driver: one bus cycle, updates the model for the coming edge
  task automatic op(int kind, logic [2:0] a, logic [7:0] d, logic tk, string tag);
    logic adv, os, cs, clr;
    logic [11:0] nxt;
    logic [7:0] ev;
    chk("R7 ovf_irq", {7'b0, ovf_irq}, {7'b0, m_ovf & m_ovfie});
    chk("R7 cmp_irq", {7'b0, cmp_irq}, {7'b0, m_cmp_f & m_cmpie});
    chk("R8 cmp_flag_o", {7'b0, cmp_flag_o}, {7'b0, m_cmp_f});
    bus_addr = a; bus_wdata = d; tick_ms = tk;
    bus_wr = (kind == 1); bus_rd = (kind == 2);
    if (kind == 2) begin
      case (a)
        3'd0: ev = {3'b0, m_sel, m_ovf, m_ovfie, m_cmpie};
        3'd1: ev = m_cnt[7:0];
        3'd2: ev = {4'b0, m_sh};
        3'd3: ev = m_rel[7:0];
        3'd4: ev = {4'b0, m_rel[11:8]};
        3'd5: ev = m_cmp[7:0];
        3'd6: ev = {4'b0, m_cmp[11:8]};
        default: ev = 8'h00;
      endcase
      exp_q.push_back(ev);
      tag_q.push_back(tag);
    end
    adv = (m_sel == 2'b01 && tk) || (m_sel == 2'b10);
    nxt = (m_cnt == 12'hFFF) ? m_rel : m_cnt + 12'd1;
    os  = adv && (m_cnt == 12'hFFF);
    cs  = adv && (nxt == m_cmp);
    clr = (kind == 2) && (a == 3'd0);
    m_ovf   = os | (m_ovf & ~clr);
    m_cmp_f = cs | (m_cmp_f & ~clr);
    if (kind == 2 && a == 3'd1) m_sh = m_cnt[11:8];
    if (adv) m_cnt = nxt;
    if (kind == 1) begin
      case (a)
        3'd0: begin m_sel = d[4:3]; m_ovfie = d[1]; m_cmpie = d[0]; end
        3'd3: m_rel[7:0]  = d;
        3'd4: m_rel[11:8] = d[3:0];
        3'd5: m_cmp[7:0]  = d;
        3'd6: m_cmp[11:8] = d[3:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag); op(1, a, d, 1'b0, tag); endtask
  task automatic rd(logic [2:0] a, string tag); op(2, a, 8'h00, 1'b0, tag); endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) op(0, 3'd0, 8'h00, 1'b0, tag);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values, R6 status layout, R10 address 7
    for (int i = 0; i < 8; i++) rd(3'(i), "R1 reset read");
    // R3 start value bytes, upper nibble dropped
    wr(3'd3, 8'hF0, "R3");
    wr(3'd4, 8'hAF, "R3");
    rd(3'd4, "R3 reload hi nibble");
    rd(3'd3, "R3 reload lo");
    // R8 compare value 0x010
    wr(3'd5, 8'h10, "R8");
    wr(3'd6, 8'hF0, "R8");
    rd(3'd6, "R8 cmp hi nibble");
    // R6 write: sys clock, both enables
    wr(3'd0, 8'h13, "R6");
    idle(30, "R8 compare hit");
    rd(3'd0, "R5 status with cmp flag");
    rd(3'd0, "R5 cleared");
    // R4 full pass, reload from FF0 rather than 000
    idle(4100, "R4 overflow");
    rd(3'd1, "R9 count lo");
    rd(3'd2, "R9 count hi");
    // R5 overflow every second cycle; reads hit set and non-set cycles
    wr(3'd3, 8'hFE, "R3");
    wr(3'd4, 8'h0F, "R3");
    idle(20, "R3 short reload");
    for (int i = 0; i < 10; i++) rd(3'd0, "R5 same-cycle set");
    // R5 write to status keeps flags; reserved select stops (R2)
    wr(3'd0, 8'hFF, "R5 status write");
    rd(3'd0, "R6 status readback");
    rd(3'd1, "R2 reserved stop");
    idle(5, "R2");
    rd(3'd1, "R2 reserved stop hold");
    // R2 tick source
    wr(3'd3, 8'h00, "R3");
    wr(3'd4, 8'h00, "R3");
    wr(3'd0, 8'h08, "R2 tick select");
    for (int i = 0; i < 60; i++) op(0, 3'd0, 8'h00, (i % 3 == 0) || (i % 7 == 1), "R2 tick");
    rd(3'd1, "R2 tick count lo");
    rd(3'd2, "R2 tick count hi");
    // R2 stopped
    wr(3'd0, 8'h00, "R2 off");
    for (int i = 0; i < 5; i++) op(0, 3'd0, 8'h00, 1'b1, "R2 off ignores tick");
    rd(3'd1, "R2 off count");
    // R9 captured nibble survives later counting
    wr(3'd0, 8'h10, "R9");
    idle(200, "R9");
    rd(3'd1, "R9 capture lo");
    idle(700, "R9");
    rd(3'd2, "R9 captured hi");
    wr(3'd0, 8'h00, "R9");
    idle(3, "end");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule